// File: doc/BRIEF.md
# Universal Counter Measurement Sequencer

This block is the measuring core of a multi-decade universal counter. It runs on the timebase clock and routes input A, input B, the timebase itself or a derived 100 Hz tick to two counters: a main BCD counter, whose value becomes the displayed result, and a reference decade counter. The reference counter counts 1, 10, 100 or 1000 reference events, and that count sets how long the main counter is enabled. When the window closes the main count and an overflow flag are copied into output latches. The main counter is then cleared, and a new cycle starts after a fixed gap.

Six functions share this one pair of counters: frequency, period, frequency ratio, time interval, unit (totalising) counting and an oscillator self-test. Hold, a measurement reset and a restart on any change of function or range keep the latched reading free of partial results. Time-interval measurement first needs one A-fall then B-fall pair before it measures. The tick divider ratios and the gap length are parameters, so the block can be run with a scaled-down timebase.

Top module: `ucnt_seq`

## Requirements
- R1: Only high-to-low transitions of `a_in` and `b_in`, as seen on successive clock edges, count as events. A level held high or low adds nothing.
- R2: Function code 0 (frequency) counts A-falls over a window of N tick periods, where range code 0/1/2/3 gives N = 1/10/100/1000. Every 4-bit digit of `digits_o` is BCD in the range 0..9, with digit 0 in bits [3:0] as the least significant.
- R3: Function code 1 (period) counts timebase cycles over N periods of input A.
- R4: Function code 2 (ratio) counts A-falls over N periods of input B.
- R5: Function code 3 (time interval) first waits for one A-fall then one B-fall, which is the priming step. It then sums the timebase cycles from each A-fall to the following B-fall over N intervals.
- R6: Function code 5 (self-test) counts timebase cycles over N tick periods, so it reads N times the active divider ratio.
- R7: Function code 4 (unit counting) counts A-falls without a window. The latch follows the counter one cycle behind, and a range change neither clears nor pauses it.
- R8: With `sel_1m` high the tick divides the timebase by `TICK_DIV_LO`; otherwise it divides by `TICK_DIV_HI`.
- R9: A change of function code, or of range code outside unit mode, abandons the measurement in progress without loading the latches, then starts a new one.
- R10: Outside unit mode, `hold` high stops and clears the measurement and keeps the latches. In unit mode counting continues while the latches stay frozen until `hold` falls.
- R11: `clr` high clears the main counter, aborts the measurement and loads zeros into `digits_o` and `ovf_o` at the next edge.
- R12: `busy_n` is low while a measurement is being primed, armed or gated, and high between measurements. Outside unit mode and `clr`, the latches load only at the end of a measurement, after `busy_n` has risen.
- R13: `ovf_o` is latched with the data. It is set when the most significant digit wrapped from 9 to 0 during that measurement, and it is clear for a measurement that did not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Measurement reset: clears, aborts, zeroes the latches |
| hold | input | 1 | Freeze the reading and suspend measuring |
| sel_1m | input | 1 | Select the low tick divider ratio |
| func | input | 3 | Function code (0 freq, 1 period, 2 ratio, 3 interval, 4 unit, 5 self-test) |
| rng | input | 2 | Range code: window of 1, 10, 100 or 1000 reference events |
| a_in | input | 1 | Input A, synchronous to clk |
| b_in | input | 1 | Input B, synchronous to clk |
| digits_o | output | 4*DIGITS | Latched BCD result |
| ovf_o | output | 1 | Latched overflow flag |
| busy_n | output | 1 | Low while a measurement is in progress |

## Verification
The bench targets the edges of the window. A design that opened the gate one cycle late or closed it one cycle early would read 79 instead of 80 in period mode, and would read other wrong values in time-interval mode. A self-test run over the widest range wraps the top digit: a missing sticky flag gives a clean-looking zero, and a flag that is never cleared shows up on the next short run. Aborts by range change and by hold are checked against the previous reading, which exposes a design that stores the partial count or fails to clear it before restarting. Unit mode is checked through range changes and hold, where a design that treats unit counting like the windowed modes would reset or stop the count.

// File: rtl/ucnt_pkg.sv
`timescale 1ns/1ps
package ucnt_pkg;

  typedef enum logic [2:0] {
    FN_FREQ   = 3'd0,
    FN_PERIOD = 3'd1,
    FN_RATIO  = 3'd2,
    FN_TINT   = 3'd3,
    FN_UNIT   = 3'd4,
    FN_OSC    = 3'd5
  } fn_e;

  typedef enum logic [2:0] {
    ST_START,
    ST_PRIME_A,
    ST_PRIME_B,
    ST_ARM,
    ST_GATE,
    ST_LATCH,
    ST_GAP
  } st_e;

  localparam int REF_W = 10;

  // last reference count index for a range code (window length minus one)
  function automatic logic [REF_W-1:0] ref_last(input logic [1:0] r);
    case (r)
      2'd0:    ref_last = REF_W'(0);
      2'd1:    ref_last = REF_W'(9);
      2'd2:    ref_last = REF_W'(99);
      default: ref_last = REF_W'(999);
    endcase
  endfunction

endpackage

// File: rtl/ucnt_tick.sv
`timescale 1ns/1ps
module ucnt_tick #(
  parameter int DIV_HI = 100000,
  parameter int DIV_LO = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_lo,
  output logic tick
);
  localparam int W = $clog2(DIV_HI + 1);

  logic [W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim   = sel_lo ? W'(DIV_LO - 1) : W'(DIV_HI - 1);
    tick  = (cnt_q >= lim);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ucnt_bcd.sv
`timescale 1ns/1ps
module ucnt_bcd #(
  parameter int DIGITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                inc,
  output logic [DIGITS*4-1:0] q,
  output logic                wrap
);
  logic [DIGITS:0] cy;
  assign cy[0] = inc;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [3:0] d_q, d_d;
    logic       nine;
    always_comb begin
      nine = (d_q == 4'd9);
      if (clr)        d_d = 4'd0;
      else if (cy[g]) d_d = nine ? 4'd0 : d_q + 4'd1;
      else            d_d = d_q;
    end
    assign cy[g+1]      = cy[g] & nine;
    assign q[g*4 +: 4]  = d_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) d_q <= 4'd0;
      else        d_q <= d_d;
    end
  end

  assign wrap = cy[DIGITS];
endmodule

// File: rtl/ucnt_ref.sv
`timescale 1ns/1ps
module ucnt_ref
  import ucnt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       ev,
  input  logic [1:0] rng,
  output logic       last
);
  logic [REF_W-1:0] cnt_q, cnt_d;

  always_comb begin
    last = ev && (cnt_q == ref_last(rng));
    if (clr)              cnt_d = '0;
    else if (ev && !last) cnt_d = cnt_q + 1'b1;
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ucnt_seq.sv
`timescale 1ns/1ps
module ucnt_seq
  import ucnt_pkg::*;
#(
  parameter int DIGITS      = 8,
  parameter int TICK_DIV_HI = 100000,
  parameter int TICK_DIV_LO = 10000,
  parameter int GAP_TICKS   = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                hold,
  input  logic                sel_1m,
  input  logic [2:0]          func,
  input  logic [1:0]          rng,
  input  logic                a_in,
  input  logic                b_in,
  output logic [DIGITS*4-1:0] digits_o,
  output logic                ovf_o,
  output logic                busy_n
);
  localparam int GW = $clog2(GAP_TICKS + 1);

  fn_e  fn;
  st_e  st_q, st_d;
  logic a_q, b_q, a_fall, b_fall;
  logic [2:0] func_q;
  logic [1:0] rng_q;
  logic unit, changed, abort, tick;
  logic main_ev, ref_src, ref_ev, ref_clr, ref_done, open_ev;
  logic main_inc, main_clr, wrap;
  logic [DIGITS*4-1:0] cnt;
  logic ovf_run_q, ovf_run_d;
  logic [GW-1:0] gap_q, gap_d;
  logic gap_done;
  logic latch_ld;
  logic [DIGITS*4-1:0] dig_q, dig_d;
  logic ovf_q, ovf_d;

  assign fn = fn_e'(func);

  // input edge and configuration history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= 1'b0;
      b_q    <= 1'b0;
      func_q <= 3'd0;
      rng_q  <= 2'd0;
    end else begin
      a_q    <= a_in;
      b_q    <= b_in;
      func_q <= func;
      rng_q  <= rng;
    end
  end

  always_comb begin
    a_fall  = a_q & ~a_in;
    b_fall  = b_q & ~b_in;
    unit    = (fn == FN_UNIT);
    changed = (func != func_q) || (!unit && (rng != rng_q));
    abort   = clr | changed | (hold & ~unit);
  end

  ucnt_tick #(.DIV_HI(TICK_DIV_HI), .DIV_LO(TICK_DIV_LO)) u_tick (
    .clk(clk), .rst_n(rst_n), .sel_lo(sel_1m), .tick(tick)
  );

  // source routing per function
  always_comb begin
    case (fn)
      FN_FREQ:   begin main_ev = a_fall; ref_src = tick;   end
      FN_PERIOD: begin main_ev = 1'b1;   ref_src = a_fall; end
      FN_RATIO:  begin main_ev = a_fall; ref_src = b_fall; end
      FN_TINT:   begin main_ev = 1'b1;   ref_src = b_fall; end
      FN_UNIT:   begin main_ev = a_fall; ref_src = 1'b0;   end
      FN_OSC:    begin main_ev = 1'b1;   ref_src = tick;   end
      default:   begin main_ev = a_fall; ref_src = tick;   end
    endcase
    open_ev  = (fn == FN_TINT) ? a_fall : ref_src;
    ref_ev   = (st_q == ST_GATE) & ref_src;
    ref_clr  = (st_q == ST_START) | abort;
    main_inc = unit ? a_fall : ((st_q == ST_GATE) & main_ev);
    main_clr = clr | changed |
               (~unit & (hold | (st_q == ST_START) | (st_q == ST_LATCH) | (st_q == ST_GAP)));
  end

  ucnt_ref u_ref (
    .clk(clk), .rst_n(rst_n), .clr(ref_clr), .ev(ref_ev), .rng(rng), .last(ref_done)
  );

  ucnt_bcd #(.DIGITS(DIGITS)) u_main (
    .clk(clk), .rst_n(rst_n), .clr(main_clr), .inc(main_inc), .q(cnt), .wrap(wrap)
  );

  // sequencing
  always_comb begin
    gap_done = tick && (gap_q == GW'(GAP_TICKS - 1));
    gap_d    = (st_q == ST_GAP) ? (tick ? gap_q + 1'b1 : gap_q) : '0;
    st_d     = st_q;
    if (unit || abort) begin
      st_d = ST_START;
    end else begin
      case (st_q)
        ST_START:   st_d = (fn == FN_TINT) ? ST_PRIME_A : ST_ARM;
        ST_PRIME_A: if (a_fall)  st_d = ST_PRIME_B;
        ST_PRIME_B: if (b_fall)  st_d = ST_ARM;
        ST_ARM:     if (open_ev) st_d = ST_GATE;
        ST_GATE: begin
          if (ref_done)                  st_d = ST_LATCH;
          else if (ref_ev && fn == FN_TINT) st_d = ST_ARM;
        end
        ST_LATCH:   st_d = ST_GAP;
        ST_GAP:     if (gap_done) st_d = ST_START;
        default:    st_d = ST_START;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_START;
      gap_q <= '0;
    end else begin
      st_q  <= st_d;
      gap_q <= gap_d;
    end
  end

  // sticky overflow and output latches
  always_comb begin
    if (main_clr)             ovf_run_d = 1'b0;
    else if (main_inc & wrap) ovf_run_d = 1'b1;
    else                      ovf_run_d = ovf_run_q;
    latch_ld = ((st_q == ST_LATCH) & ~abort) | (unit & ~hold & ~clr);
    if (clr) begin
      dig_d = '0;
      ovf_d = 1'b0;
    end else if (latch_ld) begin
      dig_d = cnt;
      ovf_d = ovf_run_q;
    end else begin
      dig_d = dig_q;
      ovf_d = ovf_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_run_q <= 1'b0;
      dig_q     <= '0;
      ovf_q     <= 1'b0;
    end else begin
      ovf_run_q <= ovf_run_d;
      dig_q     <= dig_d;
      ovf_q     <= ovf_d;
    end
  end

  assign digits_o = dig_q;
  assign ovf_o    = ovf_q;
  assign busy_n   = ~unit & ((st_q == ST_START) | (st_q == ST_LATCH) | (st_q == ST_GAP));
endmodule

// File: rtl/ucnt_seq_chk.sv
`timescale 1ns/1ps
module ucnt_seq_chk
  import ucnt_pkg::*;
#(
  parameter int DIGITS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                clr,
  input logic                hold,
  input logic [2:0]          func,
  input logic [DIGITS*4-1:0] digits_o,
  input logic                ovf_o,
  input logic                busy_n
);
  // R11: measurement reset zeroes the reading
  a_r11_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (digits_o == '0) && !ovf_o);

  // R10: hold freezes the reading in every mode
  a_r10_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clr) |=> $stable(digits_o) && $stable(ovf_o));

  // R9: a function change outside unit mode never loads the latches
  a_r9_change_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (func != $past(func) && func != FN_UNIT && !clr) |=> $stable(digits_o));

  // R12: windowed results land only after the measurement has ended
  a_r12_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(digits_o) && $past(func) != FN_UNIT && !$past(clr)) |-> $past(busy_n));

  // R2: every digit stays a decimal digit
  for (genvar g = 0; g < DIGITS; g++) begin : g_bcd
    a_r2_bcd_digit: assert property (@(posedge clk) disable iff (!rst_n)
      digits_o[g*4 +: 4] <= 4'd9);
  end
endmodule

bind ucnt_seq ucnt_seq_chk #(.DIGITS(DIGITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .hold(hold), .func(func),
  .digits_o(digits_o), .ovf_o(ovf_o), .busy_n(busy_n)
);

// File: tb/ucnt_seq_tb_top.sv
`timescale 1ns/1ps
module ucnt_seq_tb_top;
  localparam int DIGITS = 3;
  localparam int DHI    = 40;
  localparam int DLO    = 8;
  localparam int GAPT   = 2;

  logic clk = 1'b0;
  logic rst_n, clr, hold, sel_1m, a_in, b_in;
  logic [2:0] func;
  logic [1:0] rng;
  logic [DIGITS*4-1:0] digits_o;
  logic ovf_o, busy_n;

  always #2.5 clk = ~clk;

  ucnt_seq #(.DIGITS(DIGITS), .TICK_DIV_HI(DHI), .TICK_DIV_LO(DLO), .GAP_TICKS(GAPT)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .hold(hold), .sel_1m(sel_1m),
    .func(func), .rng(rng), .a_in(a_in), .b_in(b_in),
    .digits_o(digits_o), .ovf_o(ovf_o), .busy_n(busy_n)
  );

  int nchk = 0, nfail = 0;

  // stimulus generators
  int  cyc_n = 0;
  int  pa = 8, pb = 40, bdel = 0;
  bit  en_a = 0, en_b = 0, a_man = 0;
  always @(negedge clk) begin
    cyc_n++;
    a_in = a_man | (en_a && ((cyc_n % pa) < pa / 2));
    b_in = en_b && (((cyc_n + pb - bdel) % pb) < pb / 2);
  end

  function automatic logic [DIGITS*4-1:0] to_bcd(input int v);
    logic [DIGITS*4-1:0] r;
    int x = v;
    for (int i = 0; i < DIGITS; i++) begin
      r[i*4 +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { int val; bit ovf; string tag; } exp_t;
  exp_t exp_q[$];

  initial begin
    bit pb_q = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && exp_q.size() > 0 && !pb_q && busy_n) begin
        @(negedge clk);
        check({exp_q[0].tag, " digits"}, 32'(digits_o), 32'(to_bcd(exp_q[0].val)));
        check({exp_q[0].tag, " ovf"}, 32'(ovf_o), 32'(exp_q[0].ovf));
        void'(exp_q.pop_front());
      end
      pb_q = busy_n;
    end
  end

  task automatic wait_q();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic run_meas(input int f, input int r, input bit s1m, input int pa_, input int pb_,
                          input int bd, input bit ea, input bit eb, input int ev, input bit eo,
                          input string tag);
    exp_t e;
    @(negedge clk);
    clr = 1; func = 3'(f); rng = 2'(r); sel_1m = s1m;
    pa = pa_; pb = pb_; bdel = bd; en_a = ea; en_b = eb;
    @(negedge clk);
    clr = 0;
    repeat (2) @(negedge clk);
    e.val = ev; e.ovf = eo; e.tag = tag;
    exp_q.push_back(e);
    wait_q();
  endtask

  task automatic a_pulse();
    @(negedge clk); a_man = 1;
    repeat (2) @(negedge clk);
    a_man = 0;
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    exp_t e;
    rst_n = 0; clr = 0; hold = 0; sel_1m = 0; func = 3'd0; rng = 2'd0;
    a_in = 0; b_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11 reset digits", 32'(digits_o), 32'd0);
    check("R11 reset ovf", 32'(ovf_o), 32'd0);

    run_meas(0, 1, 0, 8, 40, 0, 1, 0, 50, 0, "R2 R1 freq rng1");
    run_meas(0, 0, 0, 8, 40, 0, 1, 0, 5, 0, "R2 freq rng0");
    run_meas(1, 1, 0, 8, 40, 0, 1, 0, 80, 0, "R3 period rng1");
    run_meas(1, 0, 0, 12, 40, 0, 1, 0, 12, 0, "R3 period rng0");
    run_meas(2, 1, 0, 8, 40, 0, 1, 1, 50, 0, "R4 ratio rng1");
    run_meas(3, 1, 0, 16, 16, 5, 1, 1, 50, 0, "R5 interval rng1");
    run_meas(3, 0, 0, 16, 16, 5, 1, 1, 5, 0, "R5 interval rng0");
    run_meas(5, 1, 0, 8, 40, 0, 0, 0, 400, 0, "R6 selftest rng1");
    run_meas(5, 1, 1, 8, 40, 0, 0, 0, 80, 0, "R8 selftest low divider");
    run_meas(0, 2, 1, 8, 40, 0, 1, 0, 100, 0, "R8 freq low divider");
    run_meas(5, 3, 0, 8, 40, 0, 0, 0, 0, 1, "R13 overflow set");
    run_meas(5, 0, 0, 8, 40, 0, 0, 0, 40, 0, "R13 overflow cleared");

    // R12: idle right after the result
    check("R12 busy_n high in gap", 32'(busy_n), 32'd1);

    // R9: abort by function change then by range change, latch keeps 40
    @(negedge clk);
    func = 3'd0; rng = 2'd2; pa = 8; en_a = 1;
    repeat (600) @(negedge clk);
    check("R12 busy_n low in gate", 32'(busy_n), 32'd0);
    check("R9 no load after function change", 32'(digits_o), 32'(to_bcd(40)));
    rng = 2'd1;
    repeat (2) @(negedge clk);
    check("R9 no load after range change", 32'(digits_o), 32'(to_bcd(40)));
    e.val = 50; e.ovf = 0; e.tag = "R9 restart after range change";
    exp_q.push_back(e);
    wait_q();

    // R10: hold outside unit mode
    while (busy_n) @(negedge clk);
    repeat (50) @(negedge clk);
    hold = 1;
    repeat (200) @(negedge clk);
    check("R10 hold keeps reading", 32'(digits_o), 32'(to_bcd(50)));
    check("R10 hold idles", 32'(busy_n), 32'd1);
    hold = 0;
    repeat (2) @(negedge clk);
    e.val = 50; e.ovf = 0; e.tag = "R10 fresh count after hold";
    exp_q.push_back(e);
    wait_q();

    // R7 / R1: unit counting with manual pulses
    @(negedge clk);
    clr = 1; func = 3'd4; en_a = 0; en_b = 0;
    @(negedge clk);
    clr = 0;
    for (int i = 0; i < 7; i++) a_pulse();
    repeat (3) @(negedge clk);
    check("R7 R1 unit count 7", 32'(digits_o), 32'(to_bcd(7)));
    rng = 2'd3;
    for (int i = 0; i < 3; i++) a_pulse();
    repeat (3) @(negedge clk);
    check("R7 range change ignored", 32'(digits_o), 32'(to_bcd(10)));
    hold = 1;
    for (int i = 0; i < 4; i++) a_pulse();
    repeat (3) @(negedge clk);
    check("R10 unit hold freezes", 32'(digits_o), 32'(to_bcd(10)));
    check("R7 unit busy_n low", 32'(busy_n), 32'd0);
    hold = 0;
    repeat (3) @(negedge clk);
    check("R10 unit counts through hold", 32'(digits_o), 32'(to_bcd(14)));
    clr = 1;
    @(negedge clk);
    clr = 0;
    check("R11 clr zeroes", 32'(digits_o), 32'd0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule